// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. The framing is chosen at run time through static configuration pins: the number of data bits (5 to 8), whether a parity bit is added and whether it is even or odd, one or two stop bits, which end of the word goes first, and whether the line uses normal or inverted levels. Bit timing comes from a one-cycle `baud_tick` pulse that an external divider supplies. The block does not generate the baud rate itself.

Words enter through a valid/ready stream port. A word is taken on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` stays low for the whole frame, so a producer that raises `s_valid` during a frame has to hold its word and its valid until `s_ready` returns. Every configuration pin is captured together with the word and kept until the frame ends. Changes made to them during a frame only take effect on the next frame. Between frames the line rests at its inactive level. `busy` is high for as long as a frame is in progress.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `s_ready` is 1 and `busy` is 0. While idle, the line sits at the inactive level (1 with `cfg_invert`=0, 0 with `cfg_invert`=1), one cycle after `cfg_invert` is applied. After the last stop bit the line returns to the inactive level of the frame that just ended.
- R2: A word is accepted on a rising edge with `s_valid`=1 and `s_ready`=1. From the next cycle `busy` is 1 and `s_ready` is 0, and they stay that way until the cycle after the baud tick that ends the last stop bit. A word offered while `s_ready`=0 is not taken.
- R3: The first baud tick after acceptance starts the start bit (active level 0 in normal polarity). Each later tick starts the next bit, so every bit lasts exactly one tick interval. The line changes only in the cycle after a tick.
- R4: `cfg_len` selects the data length N = 5 + `cfg_len` (00=5, 01=6, 10=7, 11=8). Bits of `s_data` at index N and above are ignored.
- R5: With `cfg_msb_first`=0 the data bits go out as `s_data[0]` up to `s_data[N-1]`. With `cfg_msb_first`=1 they go out as `s_data[N-1]` down to `s_data[0]`.
- R6: With `cfg_par_en`=1, one parity bit follows the data bits. With `cfg_par_odd`=0 the N data bits plus the parity bit hold an even number of ones. With `cfg_par_odd`=1 they hold an odd number. With `cfg_par_en`=0 no parity bit is sent.
- R7: `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two. A stop bit is at level 1 in normal polarity.
- R8: With `cfg_invert`=1, every level on the line is inverted: idle, start, data, parity and stop.
- R9: All configuration pins are captured on the acceptance edge. Changing them during a frame does not change that frame.
- R10: A frame is 1 + N + parity + stop bits long, which is 7 bits at the least and 12 at the most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse that marks a bit boundary |
| s_valid | input | 1 | Word on `s_data` is offered |
| s_ready | output | 1 | Block can take a word this cycle |
| s_data | input | 8 | Data word; low N bits are used |
| cfg_len | input | 2 | Data length code, N = 5 + code |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_msb_first | input | 1 | 1 = most significant data bit first |
| cfg_invert | input | 1 | 1 = inverted line levels |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The bench sends 5-bit MSB-first frames with ones above bit 4. A design that reversed the full byte, or that counted the upper bits into parity, would send wrong data or parity bits. Frames with all-ones and all-zeros data use odd and even parity, which exposes a parity sense that is flipped. Inverted frames are compared bit by bit, idle level included. A design that inverted only the data, or that left the idle or stop level uninverted, would disagree at the start bit or at the end of the frame. Every word after the first is offered while the previous frame is still running, so the configuration pins change in mid-frame. A design that did not latch them would shorten, lengthen or reshape the running frame, and the per-frame bit count would show it.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  function automatic logic apply_polarity(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

endpackage

// File: rtl/uftx_word_prep.sv
module uftx_word_prep #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  parameter int CNT_W    = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_code_i,
  input  logic              msb_first_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] ordered_o,
  output logic [CNT_W-1:0]  nbits_o,
  output logic              parity_o
);

  localparam int NUM_LEN = DATA_W - MIN_BITS + 1;

  logic [NUM_LEN-1:0][DATA_W-1:0] rev_opt;
  logic [NUM_LEN-1:0][DATA_W-1:0] mask_opt;
  logic [LEN_W-1:0]               sel;
  logic [DATA_W-1:0]              masked;

  // One reversed/masked variant per supported length
  for (genvar k = 0; k < NUM_LEN; k++) begin : g_len
    localparam int W = MIN_BITS + k;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i < W) begin : g_in
        assign rev_opt[k][i]  = data_i[W-1-i];
        assign mask_opt[k][i] = 1'b1;
      end else begin : g_out
        assign rev_opt[k][i]  = 1'b0;
        assign mask_opt[k][i] = 1'b0;
      end
    end
  end

  assign sel = (len_code_i > LEN_W'(NUM_LEN - 1)) ? LEN_W'(NUM_LEN - 1) : len_code_i;

  assign masked    = data_i & mask_opt[sel];
  assign ordered_o = msb_first_i ? rev_opt[sel] : masked;
  assign nbits_o   = CNT_W'(MIN_BITS) + CNT_W'(sel);
  assign parity_o  = (^masked) ^ par_odd_i;

endmodule

// File: rtl/uftx_bit_seq.sv
module uftx_bit_seq
  import uftx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             par_en_i,
  input  logic             two_stop_i,
  output tx_state_e        state_q_o,
  output tx_state_e        state_d_o,
  output logic             data_step_o
);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] dcnt_q;
  logic [CNT_W-1:0] nbits_q;
  logic             par_en_q;
  logic             two_q;
  logic             scnt_q;
  logic             last_data;

  assign last_data = (dcnt_q == nbits_q - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept_i) state_d = ST_ALIGN;
      ST_ALIGN: if (tick_i)   state_d = ST_START;
      ST_START: if (tick_i)   state_d = ST_DATA;
      ST_DATA:  if (tick_i && last_data) state_d = par_en_q ? ST_PAR : ST_STOP;
      ST_PAR:   if (tick_i)   state_d = ST_STOP;
      ST_STOP:  if (tick_i)   state_d = (two_q && !scnt_q) ? ST_STOP : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dcnt_q   <= '0;
      nbits_q  <= '0;
      par_en_q <= 1'b0;
      two_q    <= 1'b0;
      scnt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_i) begin
        nbits_q  <= nbits_i;
        par_en_q <= par_en_i;
        two_q    <= two_stop_i;
      end
      if (state_q == ST_START && tick_i)      dcnt_q <= '0;
      else if (state_q == ST_DATA && tick_i)  dcnt_q <= dcnt_q + CNT_W'(1);
      if (state_q != ST_STOP)                 scnt_q <= 1'b0;
      else if (tick_i)                        scnt_q <= 1'b1;
    end
  end

  assign state_q_o   = state_q;
  assign state_d_o   = state_d;
  assign data_step_o = tick_i && (state_q == ST_DATA);

endmodule

// File: rtl/uftx_line_drv.sv
module uftx_line_drv
  import uftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] ordered_i,
  input  logic              parity_i,
  input  logic              invert_i,
  input  tx_state_e         state_q_i,
  input  tx_state_e         state_d_i,
  output logic              line_o
);

  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              inv_q;
  logic              line_q;
  logic              raw;
  logic              inv_eff;

  always_comb begin
    case (state_d_i)
      ST_START: raw = 1'b0;
      ST_DATA:  raw = (state_q_i == ST_DATA) ? sh_q[1] : sh_q[0];
      ST_PAR:   raw = par_q;
      default:  raw = 1'b1;
    endcase
  end

  // Idle follows the live pin; a frame and its tail use the captured value
  assign inv_eff = (state_q_i == ST_IDLE) ? invert_i : inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      par_q  <= 1'b0;
      inv_q  <= 1'b0;
      line_q <= 1'b1;
    end else begin
      if (load_i) begin
        sh_q  <= ordered_i;
        par_q <= parity_i;
        inv_q <= invert_i;
      end else if (step_i) begin
        sh_q  <= sh_q >> 1;
      end
      if (state_q_i == ST_IDLE || tick_i)
        line_q <= apply_polarity(raw, inv_eff);
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int NUM_LEN = DATA_W - MIN_BITS + 1,
  localparam int LEN_W   = (NUM_LEN > 1) ? $clog2(NUM_LEN) : 1,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  output logic              tx_line,
  output logic              busy
);

  tx_state_e         state_q, state_d;
  logic              accept;
  logic              step;
  logic [DATA_W-1:0] ordered;
  logic [CNT_W-1:0]  nbits;
  logic              parity;

  assign busy    = (state_q != ST_IDLE);
  assign s_ready = !busy;
  assign accept  = s_valid && s_ready;

  uftx_word_prep #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_prep (
    .data_i      (s_data),
    .len_code_i  (cfg_len),
    .msb_first_i (cfg_msb_first),
    .par_odd_i   (cfg_par_odd),
    .ordered_o   (ordered),
    .nbits_o     (nbits),
    .parity_o    (parity)
  );

  uftx_bit_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (baud_tick),
    .accept_i    (accept),
    .nbits_i     (nbits),
    .par_en_i    (cfg_par_en),
    .two_stop_i  (cfg_two_stop),
    .state_q_o   (state_q),
    .state_d_o   (state_d),
    .data_step_o (step)
  );

  uftx_line_drv #(.DATA_W(DATA_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (baud_tick),
    .load_i    (accept),
    .step_i    (step),
    .ordered_i (ordered),
    .parity_i  (parity),
    .invert_i  (cfg_invert),
    .state_q_i (state_q),
    .state_d_i (state_d),
    .line_o    (tx_line)
  );

endmodule

// File: rtl/uftx_checker.sv
module uftx_checker (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic s_valid,
  input logic s_ready,
  input logic busy,
  input logic tx_line,
  input logic cfg_invert
);

  logic       past_ok;
  logic [4:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok  <= 1'b0;
      tick_cnt <= '0;
    end else begin
      past_ok <= 1'b1;
      if (s_valid && s_ready)     tick_cnt <= '0;
      else if (busy && baud_tick) tick_cnt <= tick_cnt + 5'd1;
    end
  end

  // R2: an accepted word makes the block busy and closes the stream port
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (busy && !s_ready));

  // R2: the port reopens only right after a baud tick
  assert_ready_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(baud_tick));

  // R3: inside a frame the line moves only after a tick
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(tx_line));

  // R3: a frame ends on a bit boundary
  assert_end_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick));

  // R8: idle level follows the polarity pin
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !busy && $past(!busy)) |-> (tx_line == !$past(cfg_invert)));

  // R10: alignment tick plus 7..12 bit ticks per frame
  assert_frame_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tick_cnt >= 5'd8 && tick_cnt <= 5'd13));

endmodule

bind uart_frame_tx uftx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .busy       (busy),
  .tx_line    (tx_line),
  .cfg_invert (cfg_invert)
);

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic [1:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       s_ready, tx_line, busy;

  always #4 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_invert(cfg_invert), .tx_line(tx_line), .busy(busy)
  );

  int tdiv = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv <= 0;
      baud_tick <= 1'b0;
    end else if (tdiv == 7) begin
      tdiv <= 0;
      baud_tick <= 1'b1;
    end else begin
      tdiv <= tdiv + 1;
      baud_tick <= 1'b0;
    end
  end

  typedef struct {
    logic  lvl;
    bit    last;
    int    flen;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic lvl, input bit last, input int flen, input string tag);
    exp_t e;
    e.lvl = lvl; e.last = last; e.flen = flen; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: builds the expected waveform, then hands the word over
  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic pen,
                      input logic odd, input logic two, input logic msb,
                      input logic inv, input string tag, input bit scramble);
    int nb, ones, flen;
    logic pbit;
    bit waited;
    nb = 5 + int'(len);
    flen = 1 + nb + int'(pen) + 1 + int'(two);
    ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    pbit = logic'(ones % 2) ^ odd;
    push(1'b0 ^ inv, 0, flen, {"R3/", tag});
    for (int i = 0; i < nb; i++)
      push((msb ? d[nb-1-i] : d[i]) ^ inv, 0, flen, {"R5/", tag});
    if (pen) push(pbit ^ inv, 0, flen, {"R6/", tag});
    push(1'b1 ^ inv, 0, flen, {"R7/", tag});
    if (two) push(1'b1 ^ inv, 0, flen, {"R7/", tag});
    push(1'b1 ^ inv, 1, flen, {"R1/", tag});

    @(negedge clk);
    s_data = d; cfg_len = len; cfg_par_en = pen; cfg_par_odd = odd;
    cfg_two_stop = two; cfg_msb_first = msb; cfg_invert = inv;
    s_valid = 1'b1;
    waited = 0;
    while (!s_ready) begin
      if (!waited) begin
        check(busy == 1'b1 && s_ready == 1'b0, "R2", "port closed during frame", int'(s_ready), 0);
        waited = 1;
      end
      @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_data = ~d;
    if (scramble) begin
      // R9: disturb every setting in mid-frame
      cfg_len = ~len; cfg_par_en = ~pen; cfg_par_odd = ~odd;
      cfg_two_stop = ~two; cfg_msb_first = ~msb; cfg_invert = ~inv;
    end
  endtask

  // Monitor: one expected level per baud tick seen while busy
  int ticks = 0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && baud_tick && busy) begin
        @(negedge clk);
        if (q.size() == 0) begin
          check(0, "R2", "unexpected bit", int'(tx_line), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          ticks++;
          check(tx_line === e.lvl, e.tag, "line level", int'(tx_line), int'(e.lvl));
          if (e.last) begin
            check(!busy && s_ready, "R2", "idle after last stop", int'(busy), 0);
            check(ticks - 1 == e.flen, "R10", "frame bits", ticks - 1, e.flen);
            ticks = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(tx_line == 1'b1, "R1", "reset line", int'(tx_line), 1);
    check(s_ready == 1'b1, "R1", "reset ready", int'(s_ready), 1);
    check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cfg_invert = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_line == 1'b0, "R8", "inverted idle", int'(tx_line), 0);
    cfg_invert = 1'b0;
    repeat (2) @(negedge clk);
    check(tx_line == 1'b1, "R1", "normal idle", int'(tx_line), 1);

    fork
      begin
        send(8'hA5, 2'd3, 0, 0, 0, 0, 0, "R5", 0);
        send(8'hB1, 2'd3, 1, 0, 1, 1, 0, "R10", 0);
        send(8'hF3, 2'd0, 1, 1, 0, 1, 0, "R4", 0);
        send(8'h2D, 2'd1, 1, 0, 0, 0, 1, "R8", 0);
        send(8'h5A, 2'd0, 0, 0, 0, 0, 0, "R10", 0);
        send(8'h4E, 2'd2, 1, 1, 1, 0, 0, "R9", 1);
        send(8'hFF, 2'd3, 1, 1, 0, 1, 1, "R6", 0);
        send(8'h00, 2'd3, 1, 0, 1, 0, 0, "R6", 0);
        send(8'hC6, 2'd1, 0, 0, 1, 1, 1, "R9", 1);
        while (q.size() != 0 || busy) @(negedge clk);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog expired: actual 0 expected 1");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule